// File: doc/BRIEF.md
# Timer Channel Status Flags

This block keeps the status flags of one channel of a multi-channel timer, together with the 16-bit up/down counter whose wrap events set them. A count strobe steps the counter by one in the direction given by a direction input. When the counter wraps upward past its top value, a sticky overflow flag is raised. When it wraps downward past zero, a sticky underflow flag is raised, but only on channels that carry that flag and only while phase-counting mode is selected. A direction flag mirrors the direction of the last clock cycle.

Software reaches the flags through a simple bus port with a select line: select 0 addresses the 8-bit status register and select 1 addresses the counter. A flag can only be cleared by software that first read it back as 1 and then writes 0 to it. Writing 1 never clears a flag. Which bits exist depends on a channel parameter: absent flags read as fixed constants. The channel-4 variant in complementary PWM mode also raises overflow when the counter steps down from 1 to 0.

Top module: `tsr_top`

## Requirements
- R1: After reset the counter is 16'h0000 and a status read returns 16'h00C0 (bit 7 direction = 1, bit 6 = 1, bit 5 underflow = 0, bit 4 overflow = 0).
- R2: Status bit 7 holds the value of `cntUp` sampled at the previous clock edge (1 = up, 0 = down); on channel 0 it always reads 1.
- R3: A count step upward from 16'hFFFF to 16'h0000 sets status bit 4, and the bit stays set until cleared as in R5.
- R4: A count step downward from 16'h0000 to 16'hFFFF sets status bit 5 only on channels 1 and 2 with `phaseMode` = 1; in every other case bit 5 reads 0.
- R5: A status write (`busSel` = 0) with 0 in a flag's bit position clears that flag only if the last status access touching the flag was a read that returned it as 1; without such a read the flag stays set.
- R6: Writing 1 to a flag leaves it unchanged, and any status write disarms every flag, so a later 0 write needs a new read first.
- R7: When a set event and a valid clearing write for the same flag fall in the same cycle, the flag ends at 1.
- R8: On channel 4 with `compPwmMode` = 1, a count step downward from 16'h0001 to 16'h0000 sets status bit 4; other channels ignore this condition.
- R9: A status read returns bit 6 as 1, bits 3 to 0 as 0 and bits 15 to 8 as 0, whatever was written.
- R10: A write with `busSel` = 1 loads the counter with `busWrData` and raises no flag; a read with `busSel` = 1 returns the counter; otherwise each `cntTick` steps it by +1 or -1 modulo 2^16, a load taking priority over a step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| cntTick | input | 1 | Count step strobe |
| cntUp | input | 1 | Count direction, 1 = up |
| phaseMode | input | 1 | Static: phase-counting mode selected |
| compPwmMode | input | 1 | Static: complementary PWM mode selected |
| busSel | input | 1 | 0 = status register, 1 = counter |
| busWr | input | 1 | Bus write strobe |
| busRd | input | 1 | Bus read strobe |
| busWrData | input | 16 | Bus write data |
| busRdData | output | 16 | Bus read data, zero when no read |

## Verification
The clearing protocol is tried with a 0 write that has no read before it, a 1 write after a read, a 0 write after a write that used up the read, and a properly armed 0 write. These separate a correct read-then-write handshake from a plain write-0 clear and from arming that persists too long. Counter wraps are driven in both directions with the phase-counting and complementary PWM modes on and off on channels 0, 1 and 4. This shows which channel and mode gating each flag obeys. A wrap that coincides with an armed clearing write checks that setting wins.

// File: rtl/tsr_pkg.sv
`timescale 1ns/1ps
package tsr_pkg;
  // Status bit positions; software decodes these.
  localparam int DIR_BIT = 7;
  localparam int RSV_BIT = 6;
  localparam int UNF_BIT = 5;
  localparam int OVF_BIT = 4;

  // Strobes passed from control to datapath each cycle.
  typedef struct packed {
    logic loadCnt;   // counter load from bus
    logic stepCnt;   // counter steps this cycle
    logic stepUp;    // direction of step, also direction flag source
    logic setOvf;    // overflow event
    logic setUnf;    // underflow event (already channel/mode gated)
    logic statRd;    // status register read
    logic statWr;    // status register write
    logic cntRd;     // counter read
  } tsrStrobe_t;
endpackage

// File: rtl/tsr_ctrl.sv
`timescale 1ns/1ps
module tsr_ctrl
  import tsr_pkg::*;
#(
  parameter int CHANNEL = 1,
  parameter int CNT_W   = 16
) (
  input  logic             cntTick,
  input  logic             cntUp,
  input  logic             phaseMode,
  input  logic             compPwmMode,
  input  logic             busSel,
  input  logic             busWr,
  input  logic             busRd,
  input  logic [CNT_W-1:0] cntVal,
  output tsrStrobe_t       strobe
);
  localparam logic             UNF_AVAIL = (CHANNEL == 1) || (CHANNEL == 2);
  localparam logic             PWM_AVAIL = (CHANNEL == 4);
  localparam logic [CNT_W-1:0] CNT_MAX   = '1;
  localparam logic [CNT_W-1:0] CNT_ZERO  = '0;
  localparam logic [CNT_W-1:0] CNT_ONE   = {{(CNT_W-1){1'b0}}, 1'b1};

  logic loadNow, stepNow, atMax, atZero, atOne;

  always_comb begin
    loadNow = busWr && busSel;
    stepNow = cntTick && !loadNow;
    atMax   = (cntVal == CNT_MAX);
    atZero  = (cntVal == CNT_ZERO);
    atOne   = (cntVal == CNT_ONE);
  end

  always_comb begin
    strobe         = '0;
    strobe.loadCnt = loadNow;
    strobe.stepCnt = stepNow;
    strobe.stepUp  = cntUp;
    strobe.setOvf  = stepNow && ((cntUp && atMax) ||
                                 (PWM_AVAIL && compPwmMode && !cntUp && atOne));
    strobe.setUnf  = UNF_AVAIL && phaseMode && stepNow && !cntUp && atZero;
    strobe.statRd  = busRd && !busSel;
    strobe.statWr  = busWr && !busSel;
    strobe.cntRd   = busRd && busSel;
  end
endmodule

// File: rtl/tsr_datapath.sv
`timescale 1ns/1ps
module tsr_datapath
  import tsr_pkg::*;
#(
  parameter int CHANNEL = 1,
  parameter int CNT_W   = 16,
  parameter int REG_W   = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  tsrStrobe_t       strobe,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] cntVal,
  output logic [REG_W-1:0] statusByte,
  output logic [CNT_W-1:0] rdData
);
  localparam logic UNF_AVAIL = (CHANNEL == 1) || (CHANNEL == 2);
  localparam logic DIR_AVAIL = (CHANNEL != 0);
  localparam int   PAD_W     = CNT_W - REG_W;

  logic dirFlag, ovfFlag, unfFlag;
  logic ovfArm;

  // Counter: load wins over a step.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               cntVal <= '0;
    else if (strobe.loadCnt) cntVal <= wrData;
    else if (strobe.stepCnt) cntVal <= strobe.stepUp ? cntVal + 1'b1 : cntVal - 1'b1;
  end

  // Overflow flag and its read-armed latch.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovfFlag <= 1'b0;
      ovfArm  <= 1'b0;
    end else begin
      if (strobe.setOvf)
        ovfFlag <= 1'b1;
      else if (strobe.statWr && ovfArm && !wrData[OVF_BIT])
        ovfFlag <= 1'b0;
      if (strobe.statWr)      ovfArm <= 1'b0;
      else if (strobe.statRd) ovfArm <= ovfFlag;
    end
  end

  generate
    if (DIR_AVAIL) begin : g_dir
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) dirFlag <= 1'b1;
        else       dirFlag <= strobe.stepUp;
      end
    end else begin : g_noDir
      assign dirFlag = 1'b1;
    end

    if (UNF_AVAIL) begin : g_unf
      logic unfArm;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          unfFlag <= 1'b0;
          unfArm  <= 1'b0;
        end else begin
          if (strobe.setUnf)
            unfFlag <= 1'b1;
          else if (strobe.statWr && unfArm && !wrData[UNF_BIT])
            unfFlag <= 1'b0;
          if (strobe.statWr)      unfArm <= 1'b0;
          else if (strobe.statRd) unfArm <= unfFlag;
        end
      end
    end else begin : g_noUnf
      logic unusedUnf;
      assign unusedUnf = strobe.setUnf;
      assign unfFlag   = 1'b0;
    end
  endgenerate

  always_comb begin
    statusByte          = '0;
    statusByte[DIR_BIT] = dirFlag;
    statusByte[RSV_BIT] = 1'b1;
    statusByte[UNF_BIT] = unfFlag;
    statusByte[OVF_BIT] = ovfFlag;
  end

  always_comb begin
    if (strobe.cntRd)       rdData = cntVal;
    else if (strobe.statRd) rdData = {{PAD_W{1'b0}}, statusByte};
    else                    rdData = '0;
  end
endmodule

// File: rtl/tsr_top.sv
`timescale 1ns/1ps
module tsr_top
  import tsr_pkg::*;
#(
  parameter int CHANNEL = 1,
  parameter int CNT_W   = 16,
  parameter int REG_W   = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cntTick,
  input  logic             cntUp,
  input  logic             phaseMode,
  input  logic             compPwmMode,
  input  logic             busSel,
  input  logic             busWr,
  input  logic             busRd,
  input  logic [CNT_W-1:0] busWrData,
  output logic [CNT_W-1:0] busRdData
);
  tsrStrobe_t       strobe;
  logic [CNT_W-1:0] cntVal;
  logic [REG_W-1:0] statusByte;

  tsr_ctrl #(.CHANNEL(CHANNEL), .CNT_W(CNT_W)) u_ctrl (
    .cntTick(cntTick), .cntUp(cntUp), .phaseMode(phaseMode),
    .compPwmMode(compPwmMode), .busSel(busSel), .busWr(busWr),
    .busRd(busRd), .cntVal(cntVal), .strobe(strobe)
  );

  tsr_datapath #(.CHANNEL(CHANNEL), .CNT_W(CNT_W), .REG_W(REG_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(busWrData),
    .cntVal(cntVal), .statusByte(statusByte), .rdData(busRdData)
  );
endmodule

// File: rtl/tsr_checker.sv
`timescale 1ns/1ps
module tsr_checker #(
  parameter int CHANNEL = 1,
  parameter int CNT_W   = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             cntTick,
  input logic             cntUp,
  input logic             compPwmMode,
  input logic             busSel,
  input logic             busWr,
  input logic [CNT_W-1:0] busWrData,
  input logic [CNT_W-1:0] cntVal,
  input logic [7:0]       statusByte
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};
  logic load, statWr0;
  assign load    = busWr && busSel;
  assign statWr0 = busWr && !busSel && !busWrData[4];

  assert_dir_follow_R2: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (statusByte[7] == ((CHANNEL == 0) ? 1'b1 : $past(cntUp))));

  assert_ovf_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cntTick && cntUp && !load && cntVal == '1) |=> statusByte[4]);

  assert_unf_absent_R4: assert property (@(posedge clk) disable iff (!rstN)
    (CHANNEL != 1 && CHANNEL != 2) |-> !statusByte[5]);

  assert_clear_by_write0_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statusByte[4]) |-> $past(statWr0));

  assert_write1_keeps_R6: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte[4] && busWr && !busSel && busWrData[4]) |=> statusByte[4]);

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cntTick && cntUp && !load && cntVal == '1 && statWr0) |=> statusByte[4]);

  assert_pwm_ovf_R8: assert property (@(posedge clk) disable iff (!rstN)
    ((CHANNEL == 4) && compPwmMode && cntTick && !cntUp && !load && cntVal == ONE)
      |=> statusByte[4]);

  assert_fixed_bits_R9: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[6] && (statusByte[3:0] == 4'h0));

  assert_count_up_R10: assert property (@(posedge clk) disable iff (!rstN)
    (cntTick && cntUp && !load) |=> (cntVal == CNT_W'($past(cntVal) + ONE)));
endmodule

bind tsr_top tsr_checker #(.CHANNEL(CHANNEL), .CNT_W(CNT_W)) u_tsrChk (
  .clk(clk), .rstN(rstN), .cntTick(cntTick), .cntUp(cntUp),
  .compPwmMode(compPwmMode), .busSel(busSel), .busWr(busWr),
  .busWrData(busWrData), .cntVal(cntVal), .statusByte(statusByte)
);

// File: tb/tb_tsr_top.sv
`timescale 1ns/1ps
module tb_tsr_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cntTick = 1'b0, cntUp = 1'b1, phaseMode = 1'b1;
  logic busSel = 1'b0, busWr = 1'b0, busRd = 1'b0;
  logic [15:0] busWrData = '0;
  logic [15:0] rdCh1, rdCh0, rdCh4;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tsr_top #(.CHANNEL(1)) dut (.clk(clk), .rstN(rstN), .cntTick(cntTick), .cntUp(cntUp),
    .phaseMode(phaseMode), .compPwmMode(1'b1), .busSel(busSel), .busWr(busWr),
    .busRd(busRd), .busWrData(busWrData), .busRdData(rdCh1));
  tsr_top #(.CHANNEL(0)) dut0 (.clk(clk), .rstN(rstN), .cntTick(cntTick), .cntUp(cntUp),
    .phaseMode(phaseMode), .compPwmMode(1'b0), .busSel(busSel), .busWr(busWr),
    .busRd(busRd), .busWrData(busWrData), .busRdData(rdCh0));
  tsr_top #(.CHANNEL(4)) dut4 (.clk(clk), .rstN(rstN), .cntTick(cntTick), .cntUp(cntUp),
    .phaseMode(1'b1), .compPwmMode(1'b1), .busSel(busSel), .busWr(busWr),
    .busRd(busRd), .busWrData(busWrData), .busRdData(rdCh4));

  // Ops: 1 load counter, 2 step up, 3 step down, 4 read status, 5 write status, 6 read counter
  // Entry: {op[31:28], req[27:24], data[23:8], expectedStatus[7:0]}; counter reads expect data.
  localparam int NV = 24;
  localparam logic [31:0] VEC [NV] = '{
    32'h4_1_0000_C0, 32'h6_1_0000_00, 32'h1_0_FFFE_00, 32'h2_0_0000_00,
    32'h6_A_FFFF_00, 32'h2_0_0000_00, 32'h6_A_0000_00, 32'h5_0_0000_00,
    32'h4_5_0000_D0, 32'h5_0_00FF_00, 32'h5_0_0000_00, 32'h4_6_0000_D0,
    32'h5_0_0000_00, 32'h4_5_0000_C0, 32'h1_0_0001_00, 32'h3_0_0000_00,
    32'h4_2_0000_40, 32'h3_0_0000_00, 32'h4_4_0000_60, 32'h6_A_FFFF_00,
    32'h5_0_0000_00, 32'h4_5_0000_40, 32'h2_0_0000_00, 32'h4_3_0000_D0
  };

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h expected=%h", tag, got, exp);
    end
  endtask

  // Drive one cycle's inputs after a falling edge; caller samples before the rise.
  task automatic step(input logic tk, input logic up, input logic sel,
                      input logic wr, input logic rd, input logic [15:0] d);
    @(negedge clk);
    cntTick = tk; cntUp = up; busSel = sel; busWr = wr; busRd = rd; busWrData = d;
    #1;
  endtask

  task automatic idle();
    step(1'b0, cntUp, 1'b0, 1'b0, 1'b0, 16'h0);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    idle(); idle();
    @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    doReset();
    // R1: reset state on all channels
    step(1'b0, cntUp, 1'b0, 1'b0, 1'b1, 16'h0);
    check("R1 ch0 reset", rdCh0, 16'h00C0);
    check("R1 ch4 reset", rdCh4, 16'h00C0);

    doReset();
    for (int i = 0; i < NV; i++) begin
      logic [3:0] op, req;
      logic [15:0] dat;
      logic [7:0] exp;
      {op, req, dat, exp} = VEC[i];
      case (op)
        4'd1: step(1'b0, cntUp, 1'b1, 1'b1, 1'b0, dat);
        4'd2: step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0);
        4'd3: step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0);
        4'd4: begin
          step(1'b0, cntUp, 1'b0, 1'b0, 1'b1, 16'h0);
          check($sformatf("R%0d status vec%0d", req, i), rdCh1, {8'h00, exp});
        end
        4'd5: step(1'b0, cntUp, 1'b0, 1'b1, 1'b0, dat);
        default: begin
          step(1'b0, cntUp, 1'b1, 1'b0, 1'b1, 16'h0);
          check($sformatf("R%0d counter vec%0d", req, i), rdCh1, dat);
        end
      endcase
    end

    // R7: set and armed clear in one cycle; overflow is still 1 from the table
    step(1'b0, cntUp, 1'b1, 1'b1, 1'b0, 16'hFFFF);
    step(1'b0, cntUp, 1'b0, 1'b0, 1'b1, 16'h0);
    check("R7 armed read", rdCh1, 16'h00D0);
    step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0000);
    step(1'b0, cntUp, 1'b0, 1'b0, 1'b1, 16'h0);
    check("R7 set wins", rdCh1, 16'h00D0);
    step(1'b0, cntUp, 1'b1, 1'b0, 1'b1, 16'h0);
    check("R7 counter wrapped", rdCh1, 16'h0000);

    // R4: no underflow without phase-counting mode; ch0 bit 7 fixed (R2)
    doReset();
    phaseMode = 1'b0;
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0);
    step(1'b0, cntUp, 1'b0, 1'b0, 1'b1, 16'h0);
    check("R4 ch1 mode off", rdCh1, 16'h0040);
    check("R2 ch0 dir fixed", rdCh0, 16'h00C0);

    // R4: with phase-counting mode only ch1 raises underflow
    doReset();
    phaseMode = 1'b1;
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0);
    step(1'b0, cntUp, 1'b0, 1'b0, 1'b1, 16'h0);
    check("R4 ch1 mode on", rdCh1, 16'h0060);
    check("R4 ch0 reserved", rdCh0, 16'h00C0);
    check("R4 ch4 reserved", rdCh4, 16'h0040);

    // R8: ch4 complementary PWM 1 -> 0
    doReset();
    step(1'b0, cntUp, 1'b1, 1'b1, 1'b0, 16'h0002);
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0);
    step(1'b0, cntUp, 1'b0, 1'b0, 1'b1, 16'h0);
    check("R8 ch4 before", rdCh4, 16'h0040);
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0);
    step(1'b0, cntUp, 1'b0, 1'b0, 1'b1, 16'h0);
    check("R8 ch4 set", rdCh4, 16'h0050);
    check("R8 ch1 ignores", rdCh1, 16'h0040);
    idle();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    done = 1;
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog got=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule